// File: doc/BRIEF.md
# ATM Transmit Cell Error Injector

This block sits on the transmit side of an ATM cell path, between a byte-wide cell source and the transmit buffer. It frames incoming 53-byte cells from a start-of-cell flag, replaces the fifth byte with a freshly computed header check value, and passes every other byte through unchanged after one register stage. For testing how error handling further along the line behaves, two control inputs let a cell leave with a corrupted check byte, a corrupted final payload byte, or both.

The block also produces the cell-available indication that tells the source whether it may send another cell. This indication follows the buffer-room input. In the default mode it is re-evaluated only between cells. In an early mode it is also re-evaluated after the 44th payload byte, which warns the source in advance. A force-off control drops the indication at once, for example while the line side is looped back. Incoming bytes can also be checked for odd parity, and a failure raises a sticky flag that a clear pulse removes.

The sequencer has four states: `S_IDLE` (no cell open), `S_HDR` (next byte is header byte 2 to 4), `S_HEC` (next byte is byte 5) and `S_PAY` (next byte is payload byte 6 to 53). The transitions are named as follows:
- start: a write with the start flag, from any state, goes to `S_HDR`.
- hdr_done: accepting byte 4 goes from `S_HDR` to `S_HEC`.
- hec_done: accepting byte 5 goes to `S_PAY`.
- cell_done: accepting byte 53 goes from `S_PAY` back to `S_IDLE`.

Top module: `cell_err_inj`

## Requirements
- R1: A write with `tx_soc` high opens a cell at byte 1, including when a cell is already partway through (the cell restarts). Writes with `tx_soc` low while no cell is open are dropped, and `out_valid` stays 0 for them.
- R2: Each accepted byte appears on `out_data` exactly one clock later with `out_valid` high. `out_soc` is high only for byte 1. Bytes 1 to 4 and 6 to 52 leave unchanged.
- R3: Byte 5 is replaced. The new value is a CRC-8 over bytes 1 to 4, using polynomial 0x07, initial value 0 and most significant bit first, XORed with 0x55. Header 00 00 00 01 gives 0x52, and header 00 00 00 00 gives 0x55.
- R4: While `ins_hec_err` is 1, bit 0 of the outgoing byte 5 is inverted relative to R3.
- R5: While `ins_pay_err` is 1, bit 0 of outgoing byte 53 is inverted. Otherwise byte 53 passes unchanged.
- R6: While `clav_force_off` is 1, `tx_clav` is 0 in the same cycle, whatever the other inputs are.
- R7: While no cell is open, `tx_clav` follows `buf_room` one clock later. While a cell is open, it holds its value and is re-evaluated from `buf_room` when byte 53 is accepted.
- R8: With `clav_early` at 1, `tx_clav` is also re-evaluated from `buf_room` when byte 49 (payload byte 44) is accepted.
- R9: With `chk_par_en` at 1, a written byte whose data and `tx_par` together hold an even number of ones sets `par_irq` on the next clock. With `chk_par_en` at 0, parity has no effect.
- R10: `par_irq` stays set until an `irq_clr` pulse. If a new parity failure and a clear fall in the same cycle, the flag stays set.
- R11: While `rst_n` is 0, the block returns to `S_IDLE` with `out_valid`, `out_soc`, `tx_clav` and `par_irq` at 0, and all controls are in their normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | A byte is transferred on this edge |
| tx_soc | input | 1 | The current byte is byte 1 of a cell |
| tx_data | input | 8 | Cell byte from the source |
| tx_par | input | 1 | Odd parity bit for `tx_data` |
| buf_room | input | 1 | Transmit buffer can hold another full cell |
| chk_par_en | input | 1 | Enable the odd parity check |
| ins_hec_err | input | 1 | Invert bit 0 of outgoing byte 5 |
| ins_pay_err | input | 1 | Invert bit 0 of outgoing byte 53 |
| clav_force_off | input | 1 | Force `tx_clav` low |
| clav_early | input | 1 | Also re-evaluate `tx_clav` after payload byte 44 |
| irq_clr | input | 1 | Clear pulse for `par_irq` |
| tx_clav | output | 1 | Cell-available indication to the source |
| out_valid | output | 1 | `out_data` holds a cell byte |
| out_soc | output | 1 | Outgoing byte is byte 1 |
| out_data | output | 8 | Outgoing cell byte |
| par_irq | output | 1 | Sticky parity-failure flag |

## Verification
The parity monitor's set path and its software clear can fall in the same cycle. This interaction is provoked by writing a byte with wrong parity while `irq_clr` is pulsed in the same clock. The result is judged by whether `par_irq` is still high on the following cycle, and a later clear on its own is then confirmed to drop the flag. A second overlap, HEC and payload corruption enabled for the same cell, is driven from the vector table, and both inverted bits are compared against independently computed values.

// File: rtl/cei_pkg.sv
package cei_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HDR,
        S_HEC,
        S_PAY
    } cell_st_e;

    // One byte of a bitwise CRC-8, most significant bit first.
    function automatic logic [BYTE_W-1:0] crc8_step(
        input logic [BYTE_W-1:0] crc_in,
        input logic [BYTE_W-1:0] din,
        input logic [BYTE_W-1:0] poly
    );
        logic [BYTE_W-1:0] c;
        c = crc_in ^ din;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[BYTE_W-1] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/cei_seq.sv
module cei_seq
    import cei_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4,
    parameter int EARLY_POS  = 49
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic soc,
    output logic acc,
    output logic first,
    output logic is_hdr,
    output logic is_hec,
    output logic is_last,
    output logic is_early,
    output logic busy
);

    localparam int CW = $clog2(CELL_BYTES + 1);

    cell_st_e        st, st_n;
    logic [CW-1:0]   cnt, cnt_n, pos;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // Next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        pos   = CW'(cnt + 1'b1);
        if (wr && soc) begin
            pos   = CW'(1);
            cnt_n = CW'(1);
            st_n  = (HDR_BYTES == 1) ? S_HEC : S_HDR;
        end else if (wr) begin
            unique case (st)
                S_IDLE: begin
                    st_n = S_IDLE;
                end
                S_HDR: begin
                    cnt_n = pos;
                    if (pos == CW'(HDR_BYTES)) st_n = S_HEC;
                end
                S_HEC: begin
                    cnt_n = pos;
                    st_n  = S_PAY;
                end
                S_PAY: begin
                    cnt_n = pos;
                    if (pos == CW'(CELL_BYTES)) begin
                        st_n  = S_IDLE;
                        cnt_n = '0;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        acc      = wr && (soc || st != S_IDLE);
        first    = wr && soc;
        is_hdr   = acc && (soc || st == S_HDR);
        is_hec   = acc && !soc && st == S_HEC;
        is_last  = acc && !soc && st == S_PAY && pos == CW'(CELL_BYTES);
        is_early = acc && !soc && st == S_PAY && pos == CW'(EARLY_POS);
        busy     = st != S_IDLE;
    end

endmodule

// File: rtl/cei_hec.sv
module cei_hec
    import cei_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              first,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (load) begin
            crc <= crc8_step(first ? '0 : crc, din, POLY);
        end
    end

endmodule

// File: rtl/cei_clav.sv
module cei_clav (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic last,
    input  logic early_pt,
    input  logic early_en,
    input  logic room,
    input  logic force_off,
    output logic clav
);

    logic clav_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clav_q <= 1'b0;
        end else if (!busy || last || (early_en && early_pt)) begin
            clav_q <= room;
        end
    end

    assign clav = clav_q && !force_off;

endmodule

// File: rtl/cei_par.sv
module cei_par
    import cei_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [BYTE_W-1:0] din,
    input  logic              par,
    input  logic              clr,
    output logic              irq
);

    logic bad;

    assign bad = en && wr && !(^{din, par});

    always_ff @(posedge clk) begin
        if (!rst_n)   irq <= 1'b0;
        else if (bad) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end

endmodule

// File: rtl/cell_err_inj.sv
module cell_err_inj
    import cei_pkg::*;
#(
    parameter int                CELL_BYTES = 53,
    parameter int                HDR_BYTES  = 4,
    parameter int                EARLY_POS  = 49,
    parameter logic [BYTE_W-1:0] HEC_POLY   = 8'h07,
    parameter logic [BYTE_W-1:0] HEC_COSET  = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic              tx_soc,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_par,
    input  logic              buf_room,
    input  logic              chk_par_en,
    input  logic              ins_hec_err,
    input  logic              ins_pay_err,
    input  logic              clav_force_off,
    input  logic              clav_early,
    input  logic              irq_clr,
    output logic              tx_clav,
    output logic              out_valid,
    output logic              out_soc,
    output logic [BYTE_W-1:0] out_data,
    output logic              par_irq
);

    logic              acc, first, is_hdr, is_hec, is_last, is_early, seq_busy;
    logic [BYTE_W-1:0] crc, hec_byte, nxt_data;

    cei_seq #(
        .CELL_BYTES(CELL_BYTES),
        .HDR_BYTES (HDR_BYTES),
        .EARLY_POS (EARLY_POS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (tx_wr),
        .soc     (tx_soc),
        .acc     (acc),
        .first   (first),
        .is_hdr  (is_hdr),
        .is_hec  (is_hec),
        .is_last (is_last),
        .is_early(is_early),
        .busy    (seq_busy)
    );

    cei_hec #(.POLY(HEC_POLY)) u_hec (
        .clk  (clk),
        .rst_n(rst_n),
        .load (is_hdr),
        .first(first),
        .din  (tx_data),
        .crc  (crc)
    );

    cei_clav u_clav (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (seq_busy),
        .last     (is_last),
        .early_pt (is_early),
        .early_en (clav_early),
        .room     (buf_room),
        .force_off(clav_force_off),
        .clav     (tx_clav)
    );

    cei_par u_par (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (chk_par_en),
        .wr   (tx_wr),
        .din  (tx_data),
        .par  (tx_par),
        .clr  (irq_clr),
        .irq  (par_irq)
    );

    assign hec_byte = crc ^ HEC_COSET ^ {{(BYTE_W-1){1'b0}}, ins_hec_err};

    always_comb begin
        if (is_hec)       nxt_data = hec_byte;
        else if (is_last) nxt_data = tx_data ^ {{(BYTE_W-1){1'b0}}, ins_pay_err};
        else              nxt_data = tx_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= acc;
            out_soc   <= first;
            if (acc) out_data <= nxt_data;
        end
    end

endmodule

// File: rtl/cei_chk.sv
module cei_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_wr,
    input logic       tx_soc,
    input logic [7:0] tx_data,
    input logic       tx_par,
    input logic       chk_par_en,
    input logic       clav_force_off,
    input logic       irq_clr,
    input logic       tx_clav,
    input logic       out_valid,
    input logic       out_soc,
    input logic       par_irq,
    input logic       busy
);

    p_drop_stray_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_wr && !tx_soc) |=> !out_valid);

    p_soc_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);

    p_force_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clav_force_off |-> !tx_clav);

    p_clav_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_wr && !clav_force_off) ##1 !clav_force_off |-> $stable(tx_clav));

    p_par_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_par_en && tx_wr && !(^{tx_data, tx_par})) |=> par_irq);

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (par_irq && !irq_clr) |=> par_irq);

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !par_irq && !out_soc));

endmodule

bind cell_err_inj cei_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_wr         (tx_wr),
    .tx_soc        (tx_soc),
    .tx_data       (tx_data),
    .tx_par        (tx_par),
    .chk_par_en    (chk_par_en),
    .clav_force_off(clav_force_off),
    .irq_clr       (irq_clr),
    .tx_clav       (tx_clav),
    .out_valid     (out_valid),
    .out_soc       (out_soc),
    .par_irq       (par_irq),
    .busy          (seq_busy)
);

// File: tb/tb_cell_err_inj.sv
`timescale 1ns/1ps
module tb_cell_err_inj;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_wr = 1'b0, tx_soc = 1'b0, tx_par = 1'b1;
    logic [7:0] tx_data = '0;
    logic       buf_room = 1'b0, chk_par_en = 1'b0;
    logic       ins_hec_err = 1'b0, ins_pay_err = 1'b0;
    logic       clav_force_off = 1'b0, clav_early = 1'b0, irq_clr = 1'b0;
    logic       tx_clav, out_valid, out_soc, par_irq;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [7:0] got_d [1:53];
    logic       got_v [1:53];
    logic       got_s [1:53];
    logic       got_c [1:53];

    always #4 clk = ~clk;

    cell_err_inj dut (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_soc(tx_soc),
        .tx_data(tx_data), .tx_par(tx_par), .buf_room(buf_room),
        .chk_par_en(chk_par_en), .ins_hec_err(ins_hec_err),
        .ins_pay_err(ins_pay_err), .clav_force_off(clav_force_off),
        .clav_early(clav_early), .irq_clr(irq_clr), .tx_clav(tx_clav),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data),
        .par_irq(par_irq)
    );

    // hdr, ins_hec, ins_pay, last byte in, expected HEC, expected last byte
    localparam logic [57:0] VEC [5] = '{
        {32'h00000000, 1'b0, 1'b0, 8'hAA, 8'h55, 8'hAA},
        {32'h00000001, 1'b0, 1'b0, 8'h3C, 8'h52, 8'h3C},
        {32'h00000002, 1'b1, 1'b0, 8'h00, 8'h5A, 8'h00},
        {32'h00000100, 1'b0, 1'b1, 8'hF0, 8'h40, 8'hF1},
        {32'h00000001, 1'b1, 1'b1, 8'h01, 8'h53, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one byte at a falling edge, sample outputs at the next falling edge.
    task automatic send(input logic [7:0] d, input logic soc, input logic bad_par);
        tx_wr   = 1'b1;
        tx_soc  = soc;
        tx_data = d;
        tx_par  = bad_par ? (^d) : ~(^d);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        tx_wr  = 1'b0;
        tx_soc = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pay_byte(input int k);
        return 8'(k) ^ 8'hA0;
    endfunction

    // Full cell; buf_room drops to 0 when byte drop_at is driven (0 = never).
    task automatic send_cell(input logic [31:0] hdr, input logic [7:0] last_b, input int drop_at);
        for (int k = 1; k <= 53; k++) begin
            logic [7:0] d;
            if (k <= 4)       d = hdr[31-8*(k-1) -: 8];
            else if (k == 5)  d = 8'hFF;
            else if (k == 53) d = last_b;
            else              d = pay_byte(k);
            if (k == drop_at) buf_room = 1'b0;
            send(d, k == 1, 1'b0);
            got_d[k] = out_data;
            got_v[k] = out_valid;
            got_s[k] = out_soc;
            got_c[k] = tx_clav;
        end
        tx_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 out_valid", out_valid, 0);
        check("R11 tx_clav", tx_clav, 0);
        check("R11 par_irq", par_irq, 0);
        rst_n = 1'b1;
        buf_room = 1'b1;
        @(negedge clk);
        check("R7 idle clav follows room", tx_clav, 1);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < 5; v++) begin
            logic ok_hdr, ok_pay, ok_soc;
            ins_hec_err = VEC[v][25];
            ins_pay_err = VEC[v][24];
            send_cell(VEC[v][57:26], VEC[v][23:16], 0);
            idle(1);
            ok_hdr = 1'b1;
            for (int k = 1; k <= 4; k++)
                if (got_d[k] !== VEC[v][57-8*(k-1) -: 8] || got_v[k] !== 1'b1) ok_hdr = 1'b0;
            ok_pay = 1'b1;
            for (int k = 6; k <= 52; k++)
                if (got_d[k] !== pay_byte(k) || got_v[k] !== 1'b1) ok_pay = 1'b0;
            ok_soc = got_s[1];
            for (int k = 2; k <= 53; k++) if (got_s[k] !== 1'b0) ok_soc = 1'b0;
            check("R2 header unchanged", ok_hdr, 1);
            check("R2 payload unchanged", ok_pay, 1);
            check("R2 soc only on byte 1", ok_soc, 1);
            check("R3/R4 byte 5", got_d[5], VEC[v][15:8]);
            check("R5 byte 53", got_d[53], VEC[v][7:0]);
        end
        ins_hec_err = 1'b0;
        ins_pay_err = 1'b0;

        // R1: stray byte while idle is dropped
        send(8'h33, 1'b0, 1'b0);
        check("R1 stray byte dropped", out_valid, 0);
        idle(1);

        // R1: restart mid-cell, then a full cell frames from the new start
        send(8'h11, 1'b1, 1'b0);
        send(8'h22, 1'b0, 1'b0);
        send(8'h44, 1'b0, 1'b0);
        send_cell(32'h00000001, 8'h5E, 0);
        idle(1);
        check("R1 restart soc", got_s[1], 1);
        check("R1 restart HEC position", got_d[5], 8'h52);

        // R6: force off
        clav_force_off = 1'b1;
        #1;
        check("R6 force drops clav", tx_clav, 0);
        @(negedge clk);
        clav_force_off = 1'b0;
        #1;
        check("R6 release restores clav", tx_clav, 1);
        @(negedge clk);

        // R7: cell mode, room lost mid-cell, held until byte 53
        clav_early = 1'b0;
        buf_room = 1'b1;
        send_cell(32'h00000000, 8'h00, 45);
        check("R7 held after byte 49", got_c[49], 1);
        check("R7 held after byte 52", got_c[52], 1);
        check("R7 updated after byte 53", got_c[53], 0);
        buf_room = 1'b1;
        idle(1);
        check("R7 idle recovers", tx_clav, 1);

        // R8: early mode, drop after byte 49
        clav_early = 1'b1;
        send_cell(32'h00000000, 8'h00, 45);
        check("R8 held after byte 48", got_c[48], 1);
        check("R8 dropped after byte 49", got_c[49], 0);
        clav_early = 1'b0;
        buf_room = 1'b1;
        idle(2);

        // R9: parity disabled has no effect
        chk_par_en = 1'b0;
        send(8'h01, 1'b0, 1'b1);
        idle(1);
        check("R9 disabled no flag", par_irq, 0);
        chk_par_en = 1'b1;
        send(8'h03, 1'b0, 1'b0);
        idle(1);
        check("R9 good parity no flag", par_irq, 0);
        send(8'h03, 1'b0, 1'b1);
        check("R9 bad parity sets flag", par_irq, 1);
        idle(2);
        check("R10 flag sticky", par_irq, 1);
        // R10: set and clear in the same cycle, set wins
        irq_clr = 1'b1;
        send(8'h07, 1'b0, 1'b1);
        irq_clr = 1'b0;
        check("R10 set beats clear", par_irq, 1);
        tx_wr = 1'b0;
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R10 clear alone", par_irq, 0);
        chk_par_en = 1'b0;

        // R11: reset mid-cell
        send(8'h00, 1'b1, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        tx_wr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears valid", out_valid, 0);
        check("R11 reset clears clav", tx_clav, 0);
        rst_n = 1'b1;
        send(8'h55, 1'b0, 1'b0);
        check("R11 idle after reset", out_valid, 0);
        idle(1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule